// File: doc/BRIEF.md
# Pin Interrupt Sense Detector

This block watches a vector of pin levels and raises a per-pin event flag when the behaviour picked by that pin's sense-mode field occurs. Each clock it holds the level seen on the previous clock, so the levels can be compared. It then decides, pin by pin, whether a rising edge, a falling edge, any change or a low level has occurred. The pin levels it sees are the effective input values. A pin that drives its own output can therefore trigger itself, provided the surrounding logic feeds the driven value back into `pin_level`.

All pins that fire on the same clock set their bits in one shared flag register together. Each flag stays set until software writes a one to its clear bit. The interrupt request is the OR of all flags. Register decoding and input synchronisation belong to the surrounding logic. This block takes `pin_level` as already synchronous to `clk`.

Top module: `pin_event_sense`

## Requirements
- R1: The sense mode of pin i sits in `pin_mode[3*i+2:3*i]`. Each pin is governed only by its own field.
- R2: Mode 1 (any change) sets a pin's flag when its level differs from the level on the previous clock.
- R3: Mode 2 (rising) sets a pin's flag only when the previous level was 0 and the current level is 1.
- R4: Mode 3 (falling) sets a pin's flag only when the previous level was 1 and the current level is 0.
- R5: Mode 5 (low level) sets a pin's flag on every clock on which its level is 0. This includes a clock on which that flag is being cleared.
- R6: Modes 0, 4, 6 and 7 never set a flag, whatever the pin does.
- R7: A flag stays at 1 until a 1 on its `flag_clear` bit clears it. A clear and a new event on the same pin in the same clock leave the flag at 1.
- R8: Events on several pins in the same clock all set their flags on that clock.
- R9: `irq` is 1 exactly when at least one bit of `flags` is 1.
- R10: While `rst_n` is low, `flags` is all zero. The level seen during reset becomes the previous level, so a level that is unchanged when reset is released produces no edge event.
- R11: An event on the level sampled at a rising clock edge appears in `flags` just after that same edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_level | input | NPINS | Effective level of each pin, synchronous to clk |
| pin_mode | input | 3*NPINS | Sense-mode field for each pin, three bits per pin |
| flag_clear | input | NPINS | Write-one-to-clear request for each flag |
| flags | output | NPINS | Sticky event flags |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are those where a clear and a new event land on the same pin in the same clock. In one, a level-mode pin stays low while software clears it. In the other, an edge arrives together with the clear. The bench sets up both by holding a low-level pin low under a clear, and by reversing every pin while clearing all flags. The second hard case is reset release. The bench changes a pin's level while reset is held and then keeps that level steady, to show that no edge is invented. A last step moves only the top pin's mode field, to confirm where the field sits.

// File: rtl/pinsense_pkg.sv
// Shared encodings for the pin event sense detector.
// Assumes a three-bit mode field per pin; codes 6 and 7 are unused and quiet.
package pinsense_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        SENSE_OFF   = 3'd0,
        SENSE_ANY   = 3'd1,
        SENSE_RISE  = 3'd2,
        SENSE_FALL  = 3'd3,
        SENSE_NOBUF = 3'd4,
        SENSE_LOW   = 3'd5
    } sense_mode_e;

endpackage

// File: rtl/pinsense_history.sv
// Holds the pin levels seen on the previous clock.
// Assumes levels are already synchronous. The register is loaded on every
// clock, reset included, so the first clock after reset sees no false edge.
module pinsense_history #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic [NPINS-1:0] level_i,
    output logic [NPINS-1:0] prev_o
);

    logic [NPINS-1:0] prev_q;

    // Capture current levels; reset deliberately loads the same value.
    always_ff @(posedge clk) begin
        prev_q <= level_i;
    end

    assign prev_o = prev_q;

endmodule

// File: rtl/pinsense_decode.sv
// Per-pin event decision: compares current and previous level under each
// pin's sense mode and reports which pins fire this clock.
// Assumes mode fields are packed three bits per pin, pin 0 lowest.
module pinsense_decode
    import pinsense_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        cur_i,
    input  logic [NPINS-1:0]        prev_i,
    input  logic [NPINS*MODE_W-1:0] mode_i,
    output logic [NPINS-1:0]        fire_o
);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic [MODE_W-1:0] m;
        logic              hit;

        assign m = mode_i[g*MODE_W +: MODE_W];

        // Choose the event condition selected by this pin's mode.
        always_comb begin
            case (m)
                SENSE_ANY:  hit = cur_i[g] ^ prev_i[g];
                SENSE_RISE: hit = cur_i[g] & ~prev_i[g];
                SENSE_FALL: hit = ~cur_i[g] & prev_i[g];
                SENSE_LOW:  hit = ~cur_i[g];
                default:    hit = 1'b0;
            endcase
        end

        assign fire_o[g] = hit;

        // R6: quiet modes never produce an event.
        assert_quiet_modes_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (m == SENSE_OFF || m == SENSE_NOBUF || m == 3'd6 || m == 3'd7) |-> !fire_o[g]);

        // R5: a low level under level mode always fires.
        assert_low_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (m == SENSE_LOW && !cur_i[g]) |-> fire_o[g]);
    end

endmodule

// File: rtl/pinsense_flags.sv
// Sticky event flag bank with write-one-to-clear and a combined request.
// Assumes a new event outranks a clear on the same bit in the same clock.
module pinsense_flags #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] fire_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] flags_o,
    output logic             irq_o
);

    logic [NPINS-1:0] flags_q;

    // Update flags: clear requested bits, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | fire_i;
        end
    end

    assign flags_o = flags_q;
    assign irq_o   = |flags_q;

    // R7: a set flag stays set unless a clear was requested.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flags_q) & ~$past(clr_i)) & ~flags_q) == '0));

    // R8: a newly set bit always traces back to an event on the prior clock.
    assert_set_from_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((flags_q & ~$past(flags_q)) & ~$past(fire_i)) == '0));

    // R9: the request only drops after a clear was presented.
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(clr_i) != '0));

endmodule

// File: rtl/pin_event_sense.sv
// Top of the pin event sense detector: previous-level register, per-pin
// decode and sticky flag bank.
// Assumes pin_level is synchronous to clk and reset is synchronous, active low.
module pin_event_sense
    import pinsense_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPINS-1:0]        pin_level,
    input  logic [NPINS*MODE_W-1:0] pin_mode,
    input  logic [NPINS-1:0]        flag_clear,
    output logic [NPINS-1:0]        flags,
    output logic                    irq
);

    logic [NPINS-1:0] prev_lvl;
    logic [NPINS-1:0] fire;

    pinsense_history #(.NPINS(NPINS)) u_history (
        .clk     (clk),
        .level_i (pin_level),
        .prev_o  (prev_lvl)
    );

    pinsense_decode #(.NPINS(NPINS)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur_i  (pin_level),
        .prev_i (prev_lvl),
        .mode_i (pin_mode),
        .fire_o (fire)
    );

    pinsense_flags #(.NPINS(NPINS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .clr_i   (flag_clear),
        .flags_o (flags),
        .irq_o   (irq)
    );

endmodule

// File: tb/pin_event_sense_test.sv
module pin_event_sense_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_level = 8'hFF;
    logic [23:0] pin_mode;
    logic [7:0]  flag_clear = 8'h00;
    logic [7:0]  flags;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pin_event_sense #(.NPINS(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_level  (pin_level),
        .pin_mode   (pin_mode),
        .flag_clear (flag_clear),
        .flags      (flags),
        .irq        (irq)
    );

    // Pin modes 0..7: any, rise, fall, low, off, nobuf, 6, 7 (R1 layout).
    function automatic logic [23:0] build_modes();
        logic [23:0] v = '0;
        for (int i = 0; i < 8; i++) begin
            logic [2:0] m;
            case (i)
                0: m = 3'd1;
                1: m = 3'd2;
                2: m = 3'd3;
                3: m = 3'd5;
                4: m = 3'd0;
                5: m = 3'd4;
                6: m = 3'd6;
                default: m = 3'd7;
            endcase
            v[3*i +: 3] = m;
        end
        return v;
    endfunction

    // Row: {requirement, level, clear, expected flags}
    localparam int ROWS = 16;
    localparam logic [27:0] VEC [ROWS] = '{
        {4'd10, 8'hFF, 8'h00, 8'h00},   // R10 no edge after reset
        {4'd2,  8'hFE, 8'h00, 8'h01},   // R2 pin0 falls
        {4'd7,  8'hFF, 8'h00, 8'h01},   // R7 sticky
        {4'd7,  8'hFF, 8'h01, 8'h00},   // R7 clear
        {4'd3,  8'hFD, 8'h00, 8'h00},   // R3 falling ignored (R1 field of pin1)
        {4'd3,  8'hFF, 8'h00, 8'h02},   // R3 rising fires
        {4'd4,  8'hFB, 8'h02, 8'h04},   // R4 falling fires
        {4'd4,  8'hFF, 8'h04, 8'h00},   // R4 rising ignored
        {4'd5,  8'hF7, 8'h00, 8'h08},   // R5 low level
        {4'd5,  8'hF7, 8'h08, 8'h08},   // R5 reasserts over clear
        {4'd5,  8'hFF, 8'h08, 8'h00},   // R5 high: cleared
        {4'd6,  8'h0F, 8'h00, 8'h00},   // R6 quiet modes, fall
        {4'd6,  8'hFF, 8'h00, 8'h00},   // R6 quiet modes, rise
        {4'd8,  8'h00, 8'h00, 8'h0D},   // R8 several pins at once
        {4'd7,  8'hFF, 8'hFF, 8'h03},   // R7 event beats clear
        {4'd7,  8'hFF, 8'hFF, 8'h00}    // R7 clear all
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_irq(input string tag);
        logic exp_irq;
        exp_irq = (flags != 8'h00);
        checks++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s R9 irq: actual %0b expected %0b", tag, irq, exp_irq);
        end
    endtask

    // Apply inputs, pass one rising edge, sample 5 ns later.
    task automatic step(input logic [7:0] lvl, input logic [7:0] clr);
        pin_level  = lvl;
        flag_clear = clr;
        @(posedge clk);
        #5;
    endtask

    initial begin
        pin_mode = build_modes();
        repeat (3) @(posedge clk);
        #5;
        check8("R10 reset flags", flags, 8'h00);
        check_irq("R10 reset");
        rst_n = 1'b1;

        for (int r = 0; r < ROWS; r++) begin
            step(VEC[r][23:16], VEC[r][15:8]);
            check8($sformatf("R%0d row %0d", VEC[r][27:24], r), flags, VEC[r][7:0]);
            check_irq($sformatf("row %0d", r));
        end

        // R11: no change before the edge, flag just after it.
        @(negedge clk);
        pin_level  = 8'hFE;
        flag_clear = 8'h00;
        #2;
        check8("R11 before edge", flags, 8'h00);
        @(posedge clk);
        #5;
        check8("R11 after edge", flags, 8'h01);
        step(8'hFF, 8'h01);
        check8("R2 rise under clear", flags, 8'h01);
        step(8'hFF, 8'h01);
        check8("R7 cleared", flags, 8'h00);

        // R10: level changes during reset, then holds after release.
        step(8'hFE, 8'h00);
        check8("R2 pre-reset event", flags, 8'h01);
        rst_n = 1'b0;
        step(8'hFF, 8'h00);
        step(8'hFF, 8'h00);
        check8("R10 flags in reset", flags, 8'h00);
        check_irq("R10 in reset");
        rst_n = 1'b1;
        step(8'hFF, 8'h00);
        check8("R10 no edge at release", flags, 8'h00);

        // R1: only pin7's field moved to rising.
        pin_mode[23:21] = 3'd2;
        step(8'h7F, 8'h00);
        check8("R1 pin7 fall ignored", flags, 8'h00);
        step(8'hFF, 8'h00);
        check8("R1 pin7 rise", flags, 8'h80);
        check_irq("R1 pin7");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule